// File: doc/BRIEF.md
# Serial Port Enable and Clock-Output Control

This block is a byte-wide serial port with a simple register write/read interface. Frames travel as one low start bit, eight data bits sent least significant bit first, and one high stop bit. Every bit lasts 16 baud ticks. The receiver takes each bit at its midpoint. The baud tick comes from one of two sources: an internal divider loaded from a rate register, or rising edges on an external clock pin.

The control register holds the enables and the clock-select field. The enables decide four things:

- whether the transmit pin is driven,
- whether the receive pin is observed,
- how the status flags react when an enable changes,
- when the serial clock pin carries a clock.

The clock pin starts under a different condition in each framing mode, asynchronous or synchronous.

Register map, addressed by `addr_i`:

| Address | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | rate | read/write |
| 2 | transmit data | read/write |
| 3 | status | read, write-1-to-clear on bits 4:1 |
| 4 | receive data | read only |

Control bits:

| Bit(s) | Field |
|---|---|
| 0 | transmit enable |
| 1 | receive enable |
| 2 | receive interrupt enable |
| 3 | transmit-empty interrupt enable |
| 4 | transmit-end interrupt enable |
| 6:5 | clock select: 00 internal with no pin output, 01 internal with clock pin output, 1x external clock on `sck_i` |
| 7 | synchronous mode |

Status bits:

| Bit | Flag |
|---|---|
| 0 | transmit-empty |
| 1 | transmit-end |
| 2 | receive-full |
| 3 | framing error |
| 4 | overrun |

Top module: `serp_port`

## Requirements
- R1: While transmit enable (control bit 0) is 0, transmit-empty (status bit 0) reads 1. Clearing the enable aborts a frame in progress and drops the pending byte.
- R2: Clearing receive enable (control bit 1) leaves receive-full, framing error, overrun (status bits 2, 3, 4) and the receive data register unchanged.
- R3: Once transmit is enabled, `txd_o` idles high until a byte is queued. Once receive is enabled, the receiver waits for a start bit.
- R4: `txd_oe_o` equals transmit enable. While receive is disabled, frames on `rxd_i` change no flag and no data.
- R5: In asynchronous mode with clock select 01, `sck_oe_o` is 1 and `sck_o` toggles, whatever the enables. With clock select 00, `sck_oe_o` is 0.
- R6: In synchronous mode (control bit 7) with clock select 01, `sck_o` holds high with `sck_oe_o` low until receive enable is 1; after that it toggles.
- R7: With the internal clock, a bit lasts 16*(rate+1) clocks. With an external clock, a bit lasts 16 rising edges of `sck_i` and the rate register has no effect.
- R8: Frames are 1 start bit, 8 data bits (least significant bit first) and 1 stop bit. A stop bit sampled as 0 sets framing error while the byte is still stored.
- R9: A frame that completes while receive-full is 1 sets overrun and is discarded; the receive data register keeps the earlier byte.
- R10: Writing transmit data clears transmit-empty and transmit-end. Transmit-empty returns to 1 when the byte moves into the shifter. Transmit-end sets when a stop bit ends with no byte pending.
- R11: `irq_rx_o` = receive interrupt enable AND (receive-full OR framing error OR overrun). `irq_tx_o` = transmit-empty interrupt enable AND transmit-empty. `irq_tend_o` = transmit-end interrupt enable AND transmit-end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| txd_o | output | 1 | Serial transmit data |
| txd_oe_o | output | 1 | Transmit pin output enable |
| rxd_i | input | 1 | Serial receive data |
| sck_o | output | 1 | Serial clock output |
| sck_oe_o | output | 1 | Serial clock pin output enable |
| sck_i | input | 1 | External baud clock input |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_tx_o | output | 1 | Transmit-empty interrupt |
| irq_tend_o | output | 1 | Transmit-end interrupt |

## Verification
A control write takes effect on the first clock edge. The flag side effects of the enables appear one edge after that. A transmit data write clears transmit-empty on its own edge, and the load into the shifter sets it again one edge later. The bench therefore reads status immediately after the write, and again after one more negative edge, to see both values. Received flags are due at the midpoint of the stop bit plus two synchronizer stages, so receive checks are made only after the whole stop bit has been driven. Transmitted frames are sampled at bit midpoints, counted from the falling start edge. Bit lengths are measured as the low time of a frame whose start bit and first data bit are both 0, within a tolerance of one tick.

// File: rtl/serp_pkg.sv
package serp_pkg;
  localparam int DW = 8;
  localparam int BIT_TICKS = 16;
  localparam int TCNT_W = $clog2(BIT_TICKS);

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_RATE = 3'd1;
  localparam logic [2:0] A_TXD  = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_RXD  = 3'd4;

  localparam logic [1:0] CK_INT_PIN = 2'b01;

  typedef struct packed {
    logic       sync;
    logic [1:0] cks;
    logic       tend_ie;
    logic       tx_ie;
    logic       rx_ie;
    logic       re;
    logic       te;
  } ctrl_t;

  typedef struct packed {
    logic orer;
    logic fer;
    logic rdrf;
    logic tend;
    logic tdre;
  } stat_t;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} fsm_e;
endpackage

// File: rtl/serp_tick.sv
module serp_tick #(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_sel_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              ext_clk_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic [2:0]        ext_q, ext_d;
  logic              int_hit;

  assign int_hit = (cnt_q >= rate_i);

  always_comb begin
    cnt_d = int_hit ? '0 : cnt_q + 1'b1;
    ext_d = {ext_q[1:0], ext_clk_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ext_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ext_q <= ext_d;
    end
  end

  assign tick_o = ext_sel_i ? (ext_q[1] & ~ext_q[2]) : int_hit;

  p_ext_tick_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_sel_i && tick_o) |=> !tick_o);
endmodule

// File: rtl/serp_tx.sv
module serp_tx
  import serp_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         txd_o
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;

  fsm_e              st_q, st_d;
  logic [TCNT_W-1:0] cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [W-1:0]      sh_q, sh_d;
  logic              last_tick;

  assign last_tick = tick_i && (cnt_q == TCNT_W'(BIT_TICKS - 1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    done_o = 1'b0;
    if (st_q != S_IDLE && tick_i) cnt_d = last_tick ? '0 : cnt_q + 1'b1;
    case (st_q)
      S_IDLE: if (load_i) begin
        st_d  = S_START;
        cnt_d = '0;
        sh_d  = data_i;
      end
      S_START: if (last_tick) begin
        st_d  = S_DATA;
        bit_d = '0;
      end
      S_DATA: if (last_tick) begin
        sh_d = sh_q >> 1;
        if (bit_q == BW'(W - 1)) st_d = S_STOP;
        else bit_d = bit_q + 1'b1;
      end
      default: if (last_tick) begin
        st_d   = S_IDLE;
        done_o = 1'b1;
      end
    endcase
    if (!en_i) begin
      st_d   = S_IDLE;
      done_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign txd_o  = (st_q == S_START) ? 1'b0 : (st_q == S_DATA) ? sh_q[0] : 1'b1;

  p_load_when_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (st_q == S_IDLE));
  p_off_goes_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (txd_o && !busy_o));
endmodule

// File: rtl/serp_rx.sv
module serp_rx
  import serp_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         rxd_i,
  output logic [W-1:0] data_o,
  output logic         stop_o,
  output logic         done_o
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;

  fsm_e              st_q, st_d;
  logic [TCNT_W-1:0] cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [W-1:0]      sh_q, sh_d;
  logic [1:0]        sync_q;
  logic              rxs, last_tick;

  assign rxs       = sync_q[1];
  assign last_tick = tick_i && (cnt_q == TCNT_W'(BIT_TICKS - 1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    done_o = 1'b0;
    if (st_q != S_IDLE && tick_i) cnt_d = last_tick ? '0 : cnt_q + 1'b1;
    case (st_q)
      S_IDLE: if (tick_i && !rxs) begin
        st_d  = S_START;
        cnt_d = '0;
      end
      S_START: if (tick_i && cnt_q == TCNT_W'(BIT_TICKS / 2 - 1)) begin
        st_d  = rxs ? S_IDLE : S_DATA;
        cnt_d = '0;
        bit_d = '0;
      end
      S_DATA: if (last_tick) begin
        sh_d = {rxs, sh_q[W-1:1]};
        if (bit_q == BW'(W - 1)) st_d = S_STOP;
        else bit_d = bit_q + 1'b1;
      end
      default: if (last_tick) begin
        st_d   = S_IDLE;
        done_o = 1'b1;
      end
    endcase
    if (!en_i) begin
      st_d   = S_IDLE;
      done_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      sync_q <= 2'b11;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      sync_q <= {sync_q[0], rxd_i};
    end
  end

  assign data_o = sh_q;
  assign stop_o = rxs;

  p_rx_idle_when_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (st_q == S_IDLE));
endmodule

// File: rtl/serp_port.sv
module serp_port
  import serp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          txd_o,
  output logic          txd_oe_o,
  input  logic          rxd_i,
  output logic          sck_o,
  output logic          sck_oe_o,
  input  logic          sck_i,
  output logic          irq_rx_o,
  output logic          irq_tx_o,
  output logic          irq_tend_o
);
  localparam int DIV_W = $clog2(BIT_TICKS / 2);

  logic [1:0]       rst_q;
  logic             rst_n;
  ctrl_t            ctrl_q, ctrl_d;
  stat_t            stat_q, stat_d;
  logic [DW-1:0]    rate_q, rate_d, tdr_q, tdr_d, rdr_q, rdr_d;
  logic             sck_q, sck_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wr_ctrl, wr_rate, wr_tdr, wr_stat;
  logic             tick, load, tx_busy, tx_done, tx_line;
  logic             rx_done, rx_stop, sck_act;
  logic [DW-1:0]    rx_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 2'b00;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n = rst_q[1];

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_rate = wr_en_i && (addr_i == A_RATE);
  assign wr_tdr  = wr_en_i && (addr_i == A_TXD);
  assign wr_stat = wr_en_i && (addr_i == A_STAT);
  assign load    = ctrl_q.te && !stat_q.tdre && !tx_busy && !wr_tdr;
  assign sck_act = (ctrl_q.cks == CK_INT_PIN) && (!ctrl_q.sync || ctrl_q.re);

  serp_tick #(.RATE_W(DW)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_n), .ext_sel_i(ctrl_q.cks[1]),
    .rate_i(rate_q), .ext_clk_i(sck_i), .tick_o(tick));

  serp_tx #(.W(DW)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(ctrl_q.te), .tick_i(tick),
    .load_i(load), .data_i(tdr_q), .busy_o(tx_busy), .done_o(tx_done),
    .txd_o(tx_line));

  serp_rx #(.W(DW)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(ctrl_q.re), .tick_i(tick),
    .rxd_i(rxd_i), .data_o(rx_data), .stop_o(rx_stop), .done_o(rx_done));

  always_comb begin
    ctrl_d = wr_ctrl ? ctrl_t'(wdata_i) : ctrl_q;
    rate_d = wr_rate ? wdata_i : rate_q;
    tdr_d  = wr_tdr  ? wdata_i : tdr_q;
    rdr_d  = rdr_q;
    stat_d = stat_q;
    if (wr_stat) begin
      if (wdata_i[1]) stat_d.tend = 1'b0;
      if (wdata_i[2]) stat_d.rdrf = 1'b0;
      if (wdata_i[3]) stat_d.fer  = 1'b0;
      if (wdata_i[4]) stat_d.orer = 1'b0;
    end
    if (tx_done && stat_q.tdre) stat_d.tend = 1'b1;
    if (load) stat_d.tdre = 1'b1;
    if (wr_tdr) begin
      stat_d.tdre = 1'b0;
      stat_d.tend = 1'b0;
    end
    if (!ctrl_q.te) stat_d.tdre = 1'b1;
    if (rx_done) begin
      if (stat_q.rdrf) stat_d.orer = 1'b1;
      else begin
        stat_d.rdrf = 1'b1;
        stat_d.fer  = !rx_stop;
        rdr_d       = rx_data;
      end
    end
    sck_d = sck_q;
    div_d = div_q;
    if (!sck_act) begin
      sck_d = 1'b1;
      div_d = '0;
    end else if (tick) begin
      div_d = div_q + 1'b1;
      if (&div_q) sck_d = !sck_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '{orer: 1'b0, fer: 1'b0, rdrf: 1'b0, tend: 1'b1, tdre: 1'b1};
      rate_q <= '0;
      tdr_q  <= '0;
      rdr_q  <= '0;
      sck_q  <= 1'b1;
      div_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      rate_q <= rate_d;
      tdr_q  <= tdr_d;
      rdr_q  <= rdr_d;
      sck_q  <= sck_d;
      div_q  <= div_d;
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_RATE:  rdata_o = rate_q;
      A_TXD:   rdata_o = tdr_q;
      A_STAT:  rdata_o = DW'(stat_q);
      A_RXD:   rdata_o = rdr_q;
      default: rdata_o = '0;
    endcase
  end

  assign txd_o      = ctrl_q.te ? tx_line : 1'b1;
  assign txd_oe_o   = ctrl_q.te;
  assign sck_o      = sck_q;
  assign sck_oe_o   = sck_act;
  assign irq_rx_o   = ctrl_q.rx_ie && (stat_q.rdrf || stat_q.fer || stat_q.orer);
  assign irq_tx_o   = ctrl_q.tx_ie && stat_q.tdre;
  assign irq_tend_o = ctrl_q.tend_ie && stat_q.tend;

  p_tdre_when_off_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ctrl_q.te |=> stat_q.tdre);
  p_rdr_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ctrl_q.re |=> $stable(rdr_q));
  p_flags_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ctrl_q.re && !wr_stat) |=> $stable({stat_q.rdrf, stat_q.fer, stat_q.orer}));
  p_sync_sck_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ctrl_q.sync && !ctrl_q.re) |=> sck_o);
  p_overrun_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rx_done && stat_q.rdrf) |=> (stat_q.orer && $stable(rdr_q)));
  p_tdr_write_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_tdr && ctrl_q.te) |=> (!stat_q.tdre && !stat_q.tend));
endmodule

// File: tb/sim_serp_port.sv
module sim_serp_port;
  logic       clk = 1'b0;
  logic       rst_n, wr_en, rxd, sck_i;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic       txd, txd_oe, sck_o, sck_oe, irq_rx, irq_tx, irq_tend;

  always #4 clk = ~clk;

  serp_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .txd_o(txd), .txd_oe_o(txd_oe), .rxd_i(rxd), .sck_o(sck_o),
    .sck_oe_o(sck_oe), .sck_i(sck_i), .irq_rx_o(irq_rx), .irq_tx_o(irq_tx),
    .irq_tend_o(irq_tend));

  int         n_chk = 0, n_bad = 0, bit_clks = 64, mon_seen = 0;
  logic [7:0] exp_q[$];
  logic [7:0] m_got, m_exp;
  logic       m_ok, m_stop, ext_run = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_now(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic send_tx(input logic [7:0] b);
    exp_q.push_back(b);
    wr(3'd2, b);
  endtask

  task automatic wait_tend();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd3, s);
      if (s[1]) break;
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    @(negedge clk); rxd = 1'b0;
    repeat (bit_clks) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bit_clks) @(negedge clk);
    end
    rxd = stop;
    repeat (bit_clks) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bit_clks) @(negedge clk);
  endtask

  task automatic measure_low(input logic [7:0] b, output int n);
    n = 0;
    send_tx(b);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!txd) break;
    end
    while (!txd && n < 5000) begin
      @(negedge clk);
      n++;
    end
    wait_tend();
  endtask

  task automatic count_sck(input int cycles, output int n);
    logic last;
    n = 0;
    @(negedge clk);
    last = sck_o;
    repeat (cycles) begin
      @(negedge clk);
      if (sck_o != last) n++;
      last = sck_o;
    end
  endtask

  // external baud source: one rising edge every 8 clocks
  initial begin
    sck_i = 1'b0;
    forever begin
      repeat (4) @(negedge clk);
      sck_i = ext_run ? ~sck_i : 1'b0;
    end
  end

  // monitor: decode TXD frames and compare them against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (txd_oe && !txd) begin
        m_ok = 1'b1;
        repeat (bit_clks / 2) @(negedge clk);
        if (!txd_oe || txd) m_ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
          repeat (bit_clks) @(negedge clk);
          if (!txd_oe) m_ok = 1'b0;
          m_got[i] = txd;
        end
        repeat (bit_clks) @(negedge clk);
        m_stop = txd;
        if (!txd_oe) m_ok = 1'b0;
        if (!m_ok) begin
          if (exp_q.size() > 0) m_exp = exp_q.pop_front();
        end else if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected tx frame", m_got, 0);
        end else begin
          m_exp = exp_q.pop_front();
          chk(m_got == m_exp, "R8 tx byte", m_got, m_exp);
          chk(m_stop == 1'b1, "R8 tx stop bit", m_stop, 1);
          mon_seen++;
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=%0d exp=0", 1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n, seen0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    rd(3'd3, v);  chk(v == 8'h03, "R10 reset status", v, 8'h03);
    rd(3'd0, v);  chk(v == 8'h00, "R4 reset ctrl", v, 0);
    chk(!txd_oe && !sck_oe, "R4 reset pin enables", {txd_oe, sck_oe}, 0);
    chk({irq_rx, irq_tx, irq_tend} == 3'b000, "R11 reset irqs", {irq_rx, irq_tx, irq_tend}, 0);

    wr(3'd1, 8'd3);
    bit_clks = 64;
    wr(3'd0, 8'h01);
    @(negedge clk);
    chk(txd_oe == 1'b1, "R4 txd_oe follows enable", txd_oe, 1);
    chk(txd == 1'b1, "R3 mark state after enable", txd, 1);

    // queue two bytes back to back
    send_tx(8'hA5);
    rd_now(3'd3, v);
    chk(v[1:0] == 2'b00, "R10 write clears empty and end", v[1:0], 0);
    rd(3'd3, v);
    chk(v[1:0] == 2'b01, "R10 empty after move to shifter", v[1:0], 1);
    send_tx(8'h3C);
    repeat (20) @(negedge clk);
    rd_now(3'd3, v);
    chk(v[0] == 1'b0, "R10 pending byte keeps empty low", v[0], 0);
    wait_tend();
    rd_now(3'd3, v);
    chk(v[1:0] == 2'b11, "R10 end after last stop", v[1:0], 3);
    repeat (bit_clks) @(negedge clk);
    chk(mon_seen == 2, "R8 two frames seen", mon_seen, 2);

    // interrupts
    wr(3'd0, 8'h19);
    @(negedge clk);
    chk(irq_tx && irq_tend, "R11 tx irqs", {irq_tx, irq_tend}, 3);
    send_tx(8'h81);
    chk(!irq_tend, "R11 tend irq drops on write", irq_tend, 0);
    wait_tend();
    chk(irq_tend, "R11 tend irq after frame", irq_tend, 1);
    repeat (bit_clks) @(negedge clk);

    // abort a frame by clearing transmit enable with a byte pending
    wr(3'd0, 8'h01);
    send_tx(8'hF0);
    repeat (200) @(negedge clk);
    wr(3'd2, 8'h11);
    rd_now(3'd3, v);
    chk(v[0] == 1'b0, "R1 pending before disable", v[0], 0);
    wr(3'd0, 8'h00);
    rd(3'd3, v);
    chk(v[0] == 1'b1, "R1 empty forced by disable", v[0], 1);
    chk(txd_oe == 1'b0, "R4 txd_oe off", txd_oe, 0);
    repeat (12 * bit_clks) @(negedge clk);
    seen0 = mon_seen;
    wr(3'd0, 8'h01);
    repeat (12 * bit_clks) @(negedge clk);
    chk(mon_seen == seen0 && txd, "R1 pending byte dropped", mon_seen, seen0);
    wr(3'd0, 8'h00);

    // receive
    wr(3'd0, 8'h06);
    send_rx(8'h5A, 1'b1);
    rd(3'd3, v); chk(v[4:2] == 3'b001, "R3 rx frame flags", v[4:2], 1);
    rd(3'd4, v); chk(v == 8'h5A, "R8 rx data", v, 8'h5A);
    chk(irq_rx, "R11 rx irq", irq_rx, 1);
    send_rx(8'hC3, 1'b1);
    rd(3'd3, v); chk(v[4:2] == 3'b101, "R9 overrun flag", v[4:2], 5);
    rd(3'd4, v); chk(v == 8'h5A, "R9 data kept", v, 8'h5A);
    wr(3'd3, 8'h1E);
    rd(3'd3, v); chk(v[4:2] == 3'b000, "R9 flags cleared", v[4:2], 0);
    chk(!irq_rx, "R11 rx irq cleared", irq_rx, 0);
    send_rx(8'h0F, 1'b0);
    rd(3'd3, v); chk(v[4:2] == 3'b011, "R8 framing error", v[4:2], 3);
    rd(3'd4, v); chk(v == 8'h0F, "R8 byte kept with framing error", v, 8'h0F);
    send_rx(8'h77, 1'b1);
    wr(3'd0, 8'h00);
    rd(3'd3, v); chk(v[4:2] == 3'b111, "R2 flags kept after disable", v[4:2], 7);
    rd(3'd4, v); chk(v == 8'h0F, "R2 data kept after disable", v, 8'h0F);
    wr(3'd3, 8'h1C);
    send_rx(8'h99, 1'b1);
    rd(3'd3, v); chk(v[4:2] == 3'b000, "R4 rx ignored while off", v[4:2], 0);
    rd(3'd4, v); chk(v == 8'h0F, "R4 data unchanged while off", v, 8'h0F);

    // bit timing
    wr(3'd0, 8'h01);
    measure_low(8'hFE, n);
    chk(n >= 120 && n <= 132, "R7 rate 3 two-bit low time", n, 128);
    wr(3'd1, 8'd1); bit_clks = 32;
    repeat (10) @(negedge clk);
    measure_low(8'hFE, n);
    chk(n >= 58 && n <= 66, "R7 rate 1 two-bit low time", n, 64);
    repeat (bit_clks) @(negedge clk);
    ext_run = 1'b1;
    wr(3'd1, 8'd0); wr(3'd0, 8'h41); bit_clks = 128;
    repeat (40) @(negedge clk);
    measure_low(8'hFE, n);
    chk(n >= 240 && n <= 264, "R7 external clock ignores rate", n, 256);
    repeat (bit_clks) @(negedge clk);
    ext_run = 1'b0;
    wr(3'd0, 8'h00); wr(3'd1, 8'd3); bit_clks = 64;

    // clock pin
    wr(3'd0, 8'h20);
    @(negedge clk);
    chk(sck_oe, "R5 async clock pin enabled", sck_oe, 1);
    count_sck(600, n);
    chk(n >= 15, "R5 async clock toggles without enables", n, 18);
    wr(3'd0, 8'h00);
    @(negedge clk);
    chk(!sck_oe, "R5 no pin output with select 00", sck_oe, 0);
    wr(3'd0, 8'hA0);
    count_sck(300, n);
    chk(n == 0 && sck_o && !sck_oe, "R6 sync clock idle without receive", n, 0);
    wr(3'd0, 8'hA2);
    @(negedge clk);
    chk(sck_oe, "R6 sync clock pin enabled", sck_oe, 1);
    count_sck(300, n);
    chk(n >= 7, "R6 sync clock toggles with receive", n, 9);
    wr(3'd0, 8'h00);

    chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule